// File: doc/BRIEF.md
# Multiplexed LCD segment driver

This block scans a small display memory onto four common lines and a row of segment lines using quarter-duty multiplexing with half-bias drive. Every output pin carries a two-bit level code (low, mid, high, or released) that an external resistor ladder or level stage turns into a voltage. The frame is cut into eight equal half-phases: each common is selected for two of them in turn, once with the high level and once with the low level. Over a frame every segment and every common therefore spends as long high as low, and no net DC is left on the glass.

Software writes one word per segment through a write port. Each word holds one bit per common. Writes go to a pending copy, which is moved into the displayed copy only at the frame boundary, so a frame is never drawn from a half-updated memory. The highest-numbered segment pins are shared with general-purpose I/O. A per-bit select hands any of them back, and such a pin then shows the released code. With the default parameters the block has 24 segment pins, 12 of them shared, and 125 slow-clock ticks per half-phase. At a 75 kHz slow clock this gives a 75 Hz frame.

Top module: `lcd_mux_drv`

## Requirements
- R1: While reset is held, common 0 is high, commons 1 to 3 are mid, every segment that is not released is high, and the display memory is cleared.
- R2: The commons are selected one at a time in the order 0, 1, 2, 3, 0, and so on. Each stays selected for 2*HALF_TICKS clock cycles, so a frame lasts 8*HALF_TICKS cycles.
- R3: A selected common is high (code 2'b10) in the first half of its slot and low (code 2'b00) in the second half. An unselected common is mid (code 2'b01). Common c sits on com_o[2c+1:2c].
- R4: Segment s sits on seg_o[2s+1:2s], and wr_data_i bit c of its word belongs to common c. When that bit is 1 the segment drives the level opposite to the selected common; when it is 0 the segment drives the same level as the selected common. A segment that is not released is never mid.
- R5: A write, addressed by wr_addr_i with wr_en_i high, lands in the pending memory at the clock edge. The pending memory is copied to the displayed memory at the edge that ends a frame. A write made in the last cycle of a frame is therefore shown only from the frame after the next one.
- R6: gpio_sel_i bit j controls segment NUM_SEG-NUM_SHARED+j. While the bit is 1 that segment outputs the released code 2'b11, and the change takes effect in the same cycle. Segments that are not shared never output 2'b11.
- R7: A write with wr_addr_i >= NUM_SEG has no effect on any segment.
- R8: Over any frame in which the display memory and the select are unchanged, every common and every segment spends as many cycles high as it spends low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow scan clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Display memory write strobe |
| wr_addr_i | input | $clog2(NUM_SEG) | Segment index to write |
| wr_data_i | input | 4 | One bit per common for that segment |
| gpio_sel_i | input | NUM_SHARED | 1 hands a shared segment pin back to general-purpose I/O |
| com_o | output | 8 | Level codes of the four commons |
| seg_o | output | 2*NUM_SEG | Level codes of the segments |

## Verification
The bench builds the block with NUM_SEG=6, NUM_SHARED=3 and HALF_TICKS=3. A frame is then 24 cycles, and the three-bit address reaches the two illegal indices 6 and 7. Over eight frames it writes every few cycles and also in the last cycle of each frame, and it moves the select in the middle of frames. Every output is compared in every cycle with a model that the bench computes from the cycle count. This covers the deferred-write boundary, ignored addresses, and releasing a pin while a frame is running. The high/low balance is counted on the commons and the unshared segments over each full frame.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;
  localparam int NUM_COM = 4;
  localparam int NUM_HALF = 2 * NUM_COM;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_REL  = 2'b11
  } lvl_e;
endpackage

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
  parameter int HALF_TICKS = 125
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [1:0] com_idx_o,
  output logic       pol_o,
  output logic       frame_end_o
);
  localparam int TW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(HALF_TICKS - 1);

  logic [TW-1:0] tick_q;
  logic [2:0]    half_q;
  logic          half_end;

  assign half_end = (tick_q == TICK_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      half_q <= '0;
    end else if (half_end) begin
      tick_q <= '0;
      half_q <= half_q + 3'd1;
    end else begin
      tick_q <= tick_q + TW'(1);
    end
  end

  assign com_idx_o   = half_q[2:1];
  assign pol_o       = half_q[0];
  assign frame_end_o = half_end && (half_q == 3'd7);
endmodule

// File: rtl/lcd_seg_ram.sv
module lcd_seg_ram #(
  parameter int NUM_SEG = 24,
  localparam int AW = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [AW-1:0]          wr_addr_i,
  input  logic [3:0]             wr_data_i,
  input  logic                   frame_end_i,
  output logic [NUM_SEG-1:0][3:0] shown_o
);
  logic [NUM_SEG-1:0][3:0] pend_q;
  logic [NUM_SEG-1:0][3:0] shown_q;

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[s]  <= '0;
        shown_q[s] <= '0;
      end else begin
        if (wr_en_i && (wr_addr_i == AW'(s))) pend_q[s] <= wr_data_i;
        // swap at frame edge uses the word held before this edge
        if (frame_end_i) shown_q[s] <= pend_q[s];
      end
    end
  end

  assign shown_o = shown_q;
endmodule

// File: rtl/lcd_level_enc.sv
module lcd_level_enc
  import lcd_mux_pkg::*;
#(
  parameter int NUM_SEG    = 24,
  parameter int NUM_SHARED = 12
) (
  input  logic [1:0]              com_idx_i,
  input  logic                    pol_i,
  input  logic [NUM_SEG-1:0][3:0] shown_i,
  input  logic [NUM_SHARED-1:0]   gpio_sel_i,
  output logic [2*NUM_COM-1:0]    com_o,
  output logic [2*NUM_SEG-1:0]    seg_o
);
  localparam int FIRST_SHARED = NUM_SEG - NUM_SHARED;

  lvl_e sel_lvl, inv_lvl;
  assign sel_lvl = pol_i ? LVL_LOW  : LVL_HIGH;
  assign inv_lvl = pol_i ? LVL_HIGH : LVL_LOW;

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    assign com_o[2*c+:2] = (com_idx_i == 2'(c)) ? sel_lvl : LVL_MID;
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    lvl_e drive;
    assign drive = shown_i[s][com_idx_i] ? inv_lvl : sel_lvl;
    if (s >= FIRST_SHARED) begin : g_shared
      assign seg_o[2*s+:2] = gpio_sel_i[s-FIRST_SHARED] ? LVL_REL : drive;
    end else begin : g_fixed
      assign seg_o[2*s+:2] = drive;
    end
  end
endmodule

// File: rtl/lcd_mux_drv.sv
module lcd_mux_drv #(
  parameter int NUM_SEG    = 24,
  parameter int NUM_SHARED = 12,
  parameter int HALF_TICKS = 125,
  localparam int AW = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [AW-1:0]         wr_addr_i,
  input  logic [3:0]            wr_data_i,
  input  logic [NUM_SHARED-1:0] gpio_sel_i,
  output logic [7:0]            com_o,
  output logic [2*NUM_SEG-1:0]  seg_o
);
  logic [1:0]              com_idx;
  logic                    pol;
  logic                    frame_end;
  logic [NUM_SEG-1:0][3:0] shown;

  lcd_scan_timer #(.HALF_TICKS(HALF_TICKS)) u_timer (
    .clk_i, .rst_ni,
    .com_idx_o  (com_idx),
    .pol_o      (pol),
    .frame_end_o(frame_end)
  );

  lcd_seg_ram #(.NUM_SEG(NUM_SEG)) u_ram (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .frame_end_i(frame_end),
    .shown_o    (shown)
  );

  lcd_level_enc #(.NUM_SEG(NUM_SEG), .NUM_SHARED(NUM_SHARED)) u_enc (
    .com_idx_i (com_idx),
    .pol_i     (pol),
    .shown_i   (shown),
    .gpio_sel_i,
    .com_o,
    .seg_o
  );
endmodule

// File: rtl/lcd_mux_chk.sv
module lcd_mux_chk #(
  parameter int NUM_SEG    = 24,
  parameter int NUM_SHARED = 12
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_SHARED-1:0] gpio_sel_i,
  input logic [7:0]            com_o,
  input logic [2*NUM_SEG-1:0]  seg_o
);
  localparam int FIRST_SHARED = NUM_SEG - NUM_SHARED;

  logic [3:0] com_act;
  logic [1:0] act_idx;
  logic [NUM_SEG-1:0] seg_mid, seg_rel;
  logic [NUM_SEG-1:0] rel_expect;

  always_comb begin
    act_idx = '0;
    for (int c = 0; c < 4; c++) begin
      com_act[c] = (com_o[2*c+:2] != 2'b01);
      if (com_act[c]) act_idx = 2'(c);
    end
    for (int s = 0; s < NUM_SEG; s++) begin
      seg_mid[s] = (seg_o[2*s+:2] == 2'b01);
      seg_rel[s] = (seg_o[2*s+:2] == 2'b11);
      rel_expect[s] = (s >= FIRST_SHARED) ? gpio_sel_i[s-FIRST_SHARED] : 1'b0;
    end
  end

  // R3
  one_com_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(com_act) == 1);

  // R2
  com_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_idx != $past(act_idx) |-> act_idx == $past(act_idx) + 2'd1);

  // R4
  seg_not_mid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_mid == '0);

  // R6
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_rel == rel_expect);

  // R5
  seg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(com_o) && $stable(gpio_sel_i) |-> $stable(seg_o));
endmodule

bind lcd_mux_drv lcd_mux_chk #(.NUM_SEG(NUM_SEG), .NUM_SHARED(NUM_SHARED)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .gpio_sel_i(gpio_sel_i),
  .com_o(com_o), .seg_o(seg_o)
);

// File: tb/lcd_mux_drv_test.sv
module lcd_mux_drv_test;
  localparam int NS = 6, NSH = 3, HT = 3, AW = 3;
  localparam int FRAME = 8 * HT;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [AW-1:0] wr_addr = 0;
  logic [3:0] wr_data = 0;
  logic [NSH-1:0] gsel = 0;
  logic [7:0] com;
  logic [2*NS-1:0] seg;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lcd_mux_drv #(.NUM_SEG(NS), .NUM_SHARED(NSH), .HALF_TICKS(HT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .gpio_sel_i(gsel), .com_o(com), .seg_o(seg));

  logic [3:0] pend [NS], shown [NS];
  int tick, hp;
  int bal [4+NS];

  function automatic logic [7:0] exp_com(int h);
    logic [7:0] v;
    for (int c = 0; c < 4; c++)
      v[2*c+:2] = (c == h / 2) ? ((h % 2) ? 2'b00 : 2'b10) : 2'b01;
    return v;
  endfunction

  function automatic logic [2*NS-1:0] exp_seg(int h);
    logic [2*NS-1:0] v;
    for (int s = 0; s < NS; s++) begin
      logic on;
      on = shown[s][h / 2];
      if (s >= NS - NSH && gsel[s-(NS-NSH)]) v[2*s+:2] = 2'b11;
      else if (h % 2 == 0) v[2*s+:2] = on ? 2'b00 : 2'b10;
      else v[2*s+:2] = on ? 2'b10 : 2'b00;
    end
    return v;
  endfunction

  task automatic chk_com(string tag);
    checks++;
    if (com !== exp_com(hp)) begin
      errors++;
      $display("FAIL %s com actual %b expected %b", tag, com, exp_com(hp));
    end
  endtask

  task automatic chk_seg(string tag);
    checks++;
    if (seg !== exp_seg(hp)) begin
      errors++;
      $display("FAIL %s seg actual %b expected %b", tag, seg, exp_seg(hp));
    end
  endtask

  function automatic int lvl_val(logic [1:0] l);
    return (l == 2'b10) ? 1 : (l == 2'b00) ? -1 : 0;
  endfunction

  initial begin
    for (int s = 0; s < NS; s++) begin pend[s] = 0; shown[s] = 0; end
    for (int i = 0; i < 4 + NS; i++) bal[i] = 0;
    tick = 0; hp = 0;
    #12;
    chk_com("R1");
    chk_seg("R1");
    @(negedge clk);
    rst_n = 1;
    for (int k = 0; k < 8 * FRAME; k++) begin
      wr_en   = (k % 3 == 0) || (k % FRAME == FRAME - 1);
      wr_addr = AW'((k * 5 + k / FRAME) % 8);
      wr_data = 4'((k * 7 + 3) % 16);
      gsel    = NSH'((k / 10) % 8);
      #1;
      chk_com("R2 R3");
      chk_seg("R4 R5 R6 R7");
      for (int c = 0; c < 4; c++) bal[c] += lvl_val(com[2*c+:2]);
      for (int s = 0; s < NS - NSH; s++) bal[4+s] += lvl_val(seg[2*s+:2]);
      if (tick == HT - 1 && hp == 7) begin
        for (int i = 0; i < 4 + NS - NSH; i++) begin
          checks++;
          if (bal[i] != 0) begin
            errors++;
            $display("FAIL R8 output %0d balance actual %0d expected 0", i, bal[i]);
          end
          bal[i] = 0;
        end
      end
      @(posedge clk);
      if (tick == HT - 1 && hp == 7)
        for (int s = 0; s < NS; s++) shown[s] = pend[s];
      if (wr_en && wr_addr < NS) pend[wr_addr] = wr_data;
      if (tick == HT - 1) begin tick = 0; hp = (hp + 1) % 8; end
      else tick++;
      @(negedge clk);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule